// File: doc/BRIEF.md
# UU-Encoded Line Receiver with Block Checksum

This block sits behind a UART receiver. It takes printable ASCII characters one at a time and turns UU-encoded text lines back into binary bytes. Each decoded byte leaves through a valid/ready port. The block adds every delivered byte into a 32-bit running sum.

Once a fixed number of lines has arrived, the block reads one more line. That line holds a decimal checksum. The block compares it with the running sum and raises a one-cycle request, either for the acknowledge reply "OK" CR LF or for the retransmit reply "RESEND" CR LF. The request to acknowledge also marks the group as committed downstream. The request to resend marks the group as discarded, and the sender must repeat it.

A command parser pulses `start` to open a data phase. An escape character (0x1B) aborts the data phase at any time. A malformed line also ends it. In both cases the block returns to idle and waits for the next `start`.

Top module: `uu_line_rx`

## Requirements
- R1: After reset, `rx_ready` is 1 and `out_valid`, `rsp_ok`, `rsp_resend`, `fmt_err` and `aborted` are 0. Characters that arrive while idle (before `start`) are consumed and produce no byte and no pulse.
- R2: The first character of a line gives the line's byte count as (character − 0x20). The backtick 0x60 stands for a count of 0. A count-0 line consists of the header followed directly by CR LF.
- R3: Each group of 4 data characters carries the values v0..v3, where each value is (character − 0x20) and the backtick stands for 0. The group yields byte0 = {v0, v1[5:4]}, byte1 = {v1[3:0], v2[5:2]} and byte2 = {v2[1:0], v3}, delivered in that order.
- R4: In the last group of a line, bytes beyond the header's count are neither delivered nor added to the sum.
- R5: Any of the following raises `fmt_err` for one cycle and returns the block to idle with the sum and the line count cleared: a count above 45, a line character outside 0x20..0x60, anything other than CR (0x0D) after the data, anything other than LF (0x0A) after that CR, or a non-digit in the checksum line.
- R6: After 20 data lines, the next line is ASCII decimal digits ended by CR LF. It is accumulated as value×10+digit, wrapping modulo 2^32.
- R7: If the checksum equals the 32-bit sum of the bytes delivered since the last checkpoint, `rsp_ok` pulses in the cycle after the LF is accepted. The sum and the line count then clear, and a new group begins.
- R8: On a mismatch, `rsp_resend` pulses instead. The sum and the line count clear, so the repeated group is checked from zero.
- R9: An accepted 0x1B pulses `aborted` in the next cycle, in any state. The block then returns to idle with the sum and the line count cleared.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds. `rx_ready` is 0 while decoded bytes are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a data phase when idle |
| rx_data | input | 8 | Received character |
| rx_valid | input | 1 | Character present |
| rx_ready | output | 1 | Block accepts a character |
| out_data | output | 8 | Decoded byte |
| out_valid | output | 1 | Decoded byte present |
| out_ready | input | 1 | Consumer takes the byte |
| rsp_ok | output | 1 | Request the acknowledge reply; group committed |
| rsp_resend | output | 1 | Request the retransmit reply; group discarded |
| fmt_err | output | 1 | Malformed line seen |
| aborted | output | 1 | Escape character accepted |

## Verification
The hardest situation to reach is a checksum comparison that depends on everything before it. To produce one, the bench must send twenty well-formed lines whose counts include 0, 45 and values that are not multiples of three. It must also deliver the bytes under random backpressure, and it must compute the wrapping sum itself. The driver builds every line from a generator keyed by group and line. This lets a rejected group be sent again unchanged. A checksum above 2^32 covers the wrapping accumulator. Aborts and malformed lines follow, each with a fresh group afterwards, to show that the sum was cleared.

// File: rtl/uu_line_rx.sv
module uu_line_rx #(
  parameter int LINES_PER_GROUP = 20,
  parameter int MAX_BYTES       = 45,
  parameter int SUM_W           = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       rx_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       rsp_ok,
  output logic       rsp_resend,
  output logic       fmt_err,
  output logic       aborted
);
  localparam int LW = $clog2(LINES_PER_GROUP + 1);
  localparam int CW = $clog2(MAX_BYTES + 1);
  localparam logic [5:0] MAXB = 6'(MAX_BYTES);
  localparam logic [LW-1:0] LAST_LINE = LW'(LINES_PER_GROUP - 1);
  localparam logic [7:0] C_ESC = 8'h1B, C_CR = 8'h0D, C_LF = 8'h0A;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_EMIT, S_CR, S_LF, S_SUM, S_SUMLF} st_t;
  st_t st;

  logic [CW-1:0]    rem;
  logic [17:0]      quad;
  logic [1:0]       qi, nb;
  logic [23:0]      bytes;
  logic [LW-1:0]    lines;
  logic [SUM_W-1:0] sum, acc;

  wire       take   = rx_valid && rx_ready;
  wire       in_rng = (rx_data >= 8'h20) && (rx_data <= 8'h60);
  wire [7:0] off    = rx_data - 8'h20;
  wire [5:0] v6     = off[5:0];
  wire       digit  = (rx_data >= 8'h30) && (rx_data <= 8'h39);
  wire [7:0] dval   = rx_data - 8'h30;

  assign rx_ready  = (st != S_EMIT);
  assign out_valid = (st == S_EMIT);
  assign out_data  = bytes[23:16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rem <= '0; quad <= '0; qi <= '0; nb <= '0; bytes <= '0;
      lines <= '0; sum <= '0; acc <= '0;
      rsp_ok <= 1'b0; rsp_resend <= 1'b0; fmt_err <= 1'b0; aborted <= 1'b0;
    end else begin
      rsp_ok <= 1'b0; rsp_resend <= 1'b0; fmt_err <= 1'b0; aborted <= 1'b0;
      if (take && rx_data == C_ESC) begin
        aborted <= 1'b1;
        st <= S_IDLE; sum <= '0; lines <= '0;
      end else begin
        case (st)
          S_IDLE: if (start) st <= S_HDR;
          S_HDR: if (take) begin
            if (!in_rng || v6 > MAXB) begin
              fmt_err <= 1'b1; st <= S_IDLE; sum <= '0; lines <= '0;
            end else begin
              rem <= CW'(v6);
              qi  <= '0;
              st  <= (v6 == 6'd0) ? S_CR : S_DATA;
            end
          end
          S_DATA: if (take) begin
            if (!in_rng) begin
              fmt_err <= 1'b1; st <= S_IDLE; sum <= '0; lines <= '0;
            end else if (qi == 2'd3) begin
              bytes <= {quad, v6};
              nb    <= (rem >= CW'(3)) ? 2'd3 : rem[1:0];
              st    <= S_EMIT;
            end else begin
              quad <= {quad[11:0], v6};
              qi   <= qi + 2'd1;
            end
          end
          S_EMIT: if (out_ready) begin
            sum   <= sum + {{(SUM_W-8){1'b0}}, out_data};
            bytes <= {bytes[15:0], 8'h00};
            nb    <= nb - 2'd1;
            rem   <= rem - CW'(1);
            if (nb == 2'd1) begin
              qi <= '0;
              st <= (rem == CW'(1)) ? S_CR : S_DATA;
            end
          end
          S_CR: if (take) begin
            if (rx_data == C_CR) st <= S_LF;
            else begin
              fmt_err <= 1'b1; st <= S_IDLE; sum <= '0; lines <= '0;
            end
          end
          S_LF: if (take) begin
            if (rx_data != C_LF) begin
              fmt_err <= 1'b1; st <= S_IDLE; sum <= '0; lines <= '0;
            end else if (lines == LAST_LINE) begin
              lines <= '0; acc <= '0; st <= S_SUM;
            end else begin
              lines <= lines + LW'(1); st <= S_HDR;
            end
          end
          S_SUM: if (take) begin
            if (digit) acc <= acc * SUM_W'(10) + SUM_W'(dval);
            else if (rx_data == C_CR) st <= S_SUMLF;
            else begin
              fmt_err <= 1'b1; st <= S_IDLE; sum <= '0; lines <= '0;
            end
          end
          S_SUMLF: if (take) begin
            if (rx_data == C_LF) begin
              if (acc == sum) rsp_ok <= 1'b1;
              else rsp_resend <= 1'b1;
              sum <= '0; st <= S_HDR;
            end else begin
              fmt_err <= 1'b1; st <= S_IDLE; sum <= '0; lines <= '0;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10
  no_rx_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rx_ready);

  // R9
  esc_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && rx_data == C_ESC |=> aborted && !out_valid);

  // R7
  ok_after_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> $past(rx_valid && rx_ready && rx_data == C_LF));

  // R8
  resend_after_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_resend |-> $past(rx_valid && rx_ready && rx_data == C_LF) && !rsp_ok);

  // R5
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> !out_valid && !rsp_ok && !rsp_resend);
endmodule

// File: tb/uu_line_rx_tb_top.sv
`timescale 1ns/1ps
module uu_line_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_valid = 1'b0, out_ready = 1'b0;
  logic rx_ready, out_valid, rsp_ok, rsp_resend, fmt_err, aborted;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  uu_line_rx dut_i (.clk(clk), .rst_n(rst_n), .start(start), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .rsp_ok(rsp_ok), .rsp_resend(rsp_resend),
    .fmt_err(fmt_err), .aborted(aborted));

  int n_cmp = 0, n_bad = 0, seen_by = 0, seen_ev = 0, cycles = 0;
  logic [7:0] q_by[$];
  int q_ev[$];
  logic [31:0] exp_sum = 0;
  logic [7:0] lfsr = 8'hA5;
  logic stall_prev = 1'b0;
  logic [7:0] stall_data = 8'h00;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string ev_tag(input int c);
    case (c)
      1: return "R7 ok";
      2: return "R8 resend";
      3: return "R5 fmt_err";
      default: return "R9 abort";
    endcase
  endfunction

  always @(negedge clk) begin
    int code;
    if (rst_n) begin
      if (stall_prev)
        check(out_valid && out_data == stall_data, "R10 hold", out_data, stall_data);
      if (out_valid && rx_ready) check(0, "R10 rx_ready while pending", 1, 0);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = (lfsr[1:0] != 2'b00);
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
      if (out_valid && out_ready) begin
        seen_by++;
        if (q_by.size() == 0) check(0, "R3 unexpected byte", out_data, -1);
        else begin
          logic [7:0] e;
          e = q_by.pop_front();
          check(out_data == e, "R3 R4 byte", out_data, e);
        end
      end
      code = rsp_ok ? 1 : rsp_resend ? 2 : fmt_err ? 3 : aborted ? 4 : 0;
      if (code != 0) begin
        seen_ev++;
        if (q_ev.size() == 0) check(0, "unexpected event", code, 0);
        else begin
          int e;
          e = q_ev.pop_front();
          check(code == e, ev_tag(e), code, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic put(input logic [7:0] c);
    @(negedge clk);
    rx_data = c; rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  function automatic logic [7:0] enc(input logic [5:0] v);
    return (v == 6'd0) ? 8'h60 : {2'b00, v} + 8'h20;
  endfunction

  function automatic logic [7:0] gen(input int g, input int l, input int k);
    return 8'((g * 53 + l * 29 + k * 13 + k * k * 7) ^ (l << 3));
  endfunction

  task automatic send_quad(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    put(enc(b0[7:2])); put(enc({b0[1:0], b1[7:4]}));
    put(enc({b1[3:0], b2[7:6]})); put(enc(b2[5:0]));
  endtask

  // R2 R3 R4: header count, 4-to-3 packing, padding dropped
  task automatic send_line(input int g, input int l, input int cnt);
    put((cnt == 0) ? 8'h60 : 8'(cnt + 32));
    for (int k = 0; k < cnt; k += 3) begin
      logic [7:0] b[3];
      for (int j = 0; j < 3; j++) begin
        if (k + j < cnt) begin
          b[j] = gen(g, l, k + j);
          q_by.push_back(b[j]);
          exp_sum = exp_sum + {24'h0, b[j]};
        end else b[j] = 8'hFF;
      end
      send_quad(b[0], b[1], b[2]);
    end
    put(8'h0D); put(8'h0A);
  endtask

  task automatic put_dec(input logic [63:0] v);
    logic [7:0] d[20];
    int n = 0;
    if (v == 0) begin d[0] = 8'h30; n = 1; end
    while (v != 0) begin d[n] = 8'h30 + 8'(v % 10); v = v / 10; n++; end
    for (int i = n - 1; i >= 0; i--) put(d[i]);
    put(8'h0D); put(8'h0A);
  endtask

  // R6: twenty lines, then decimal checksum plus offset
  task automatic send_group(input int g, input logic [63:0] add, input int ev);
    exp_sum = 0;
    for (int l = 0; l < 20; l++) begin
      int cnt = (l == 3) ? 0 : (l == 5) ? 45 : (l * 17 + 1) % 46;
      send_line(g, l, cnt);
    end
    q_ev.push_back(ev);
    put_dec({32'h0, exp_sum} + add);
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    int sb, se;
    repeat (4) @(negedge clk);
    check(rx_ready == 1'b1, "R1 rx_ready after reset", rx_ready, 1);
    check(out_valid == 1'b0 && !rsp_ok && !rsp_resend && !fmt_err && !aborted,
          "R1 outputs after reset", out_valid, 0);
    rst_n = 1'b1;
    sb = seen_by; se = seen_ev;
    put(8'h21); put(8'h41); put(8'h42); put(8'h43); put(8'h44); put(8'h0D); put(8'h0A);
    settle();
    check(seen_by == sb && seen_ev == se, "R1 idle ignores characters", seen_by + seen_ev, sb + se);

    pulse_start();
    send_group(0, 0, 1);
    send_group(1, 1, 2);
    send_group(1, 64'h1_0000_0000 * 3, 1);
    settle();

    // R9: abort mid-line, then idle ignores, sum cleared for next group
    put(8'h26);
    send_quad(8'h11, 8'h22, 8'h33);
    q_by.push_back(8'h11); q_by.push_back(8'h22); q_by.push_back(8'h33);
    put(8'h41); put(8'h42);
    q_ev.push_back(4);
    put(8'h1B);
    settle();
    sb = seen_by; se = seen_ev;
    put(8'h21); put(8'h41); put(8'h41); put(8'h41); put(8'h41);
    settle();
    check(seen_by == sb && seen_ev == se, "R9 idle after abort", seen_by + seen_ev, sb + se);

    // R5: count above 45
    pulse_start();
    q_ev.push_back(3); put(8'h4E);
    settle();
    // R5: extra character where CR belongs
    pulse_start();
    put(8'h21); send_quad(8'h41, 8'h00, 8'h00); q_by.push_back(8'h41);
    q_ev.push_back(3); put(8'h41);
    settle();
    // R5: out-of-range data character
    pulse_start();
    put(8'h23); put(8'h41);
    q_ev.push_back(3); put(8'h7E);
    settle();
    // R5: non-digit in checksum line, after a full group
    pulse_start();
    exp_sum = 0;
    for (int l = 0; l < 20; l++) send_line(3, l, (l % 4) + 1);
    put(8'h31); q_ev.push_back(3); put(8'h58);
    settle();
    // R5 R7: sum cleared by error, next group accepted
    pulse_start();
    send_group(2, 0, 1);
    settle();
    // R9: escape in the checksum line
    exp_sum = 0;
    for (int l = 0; l < 20; l++) send_line(4, l, 3);
    put(8'h32); q_ev.push_back(4); put(8'h1B);
    settle();
    pulse_start();
    send_group(5, 0, 1);
    settle();

    check(q_by.size() == 0, "R3 all bytes delivered", q_by.size(), 0);
    check(q_ev.size() == 0, "R7 all responses seen", q_ev.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule